// File: doc/BRIEF.md
# Compare-Match Timer with Handshake Status Flags

This block is an up-counting timer with two compare registers. When the counter steps onto a compare value, a sticky status flag sets, and an overflow flag sets when the counter wraps from all ones to zero. A match on compare register B updates a single output pin according to a two-bit action field. A match on compare register A can issue a one-cycle conversion-start strobe when a trigger enable bit is set.

Software reaches the counter, both compare registers and a control/status byte through a small register bus with a combinational read path. A status flag is cleared by a two-step exchange. Software first reads the control/status byte while the flag shows 1, then writes 0 to that bit. A zero written without that earlier read does nothing, so a flag cannot be lost by a careless write.

Top module: `mtmr_top`

## Requirements
- R1: After reset the control/status byte reads 0x00, the counter reads 0x00, both compare registers read 0xFF, `tmr_out` is 0 and `conv_req` is 0.
- R2: The bus address selects the register: 0 is the counter, 1 is compare A, 2 is compare B and 3 is control/status. The control/status layout is bit 7 flag B, bit 6 flag A, bit 5 overflow flag, bit 4 trigger enable, and bits 3:2 the pin action. Bits 4:2 read back as written. Bits 1:0 always read 0 and ignore writes.
- R3: While `cnt_en` is 1 the counter advances by one on each clock. A bus write to the counter takes precedence over the increment in the same cycle.
- R4: Flag A (or B) sets at the clock edge where the counter advances to a value equal to compare A (or B). It is visible on the bus in the following cycle.
- R5: The overflow flag sets at the clock edge where the counter advances from 0xFF to 0x00.
- R6: A flag clears only when a 0 is written to its bit after a read of address 3 that returned that flag as 1. Any write of 0 to the bit cancels the pending read. A write of 0 with no such read leaves the flag set, and a write of 1 never changes a flag.
- R7: If a flag's set event and a valid clearing write occur in the same cycle, the flag remains 1.
- R8: When trigger enable is 1, `conv_req` is high for exactly the one cycle after the edge where the counter reaches compare A. When trigger enable is 0, `conv_req` stays 0.
- R9: At the edge where the counter reaches compare B, `tmr_out` follows the action field: 00 holds, 01 drives 0, 10 drives 1, 11 toggles. At no other time does `tmr_out` change.
- R10: Loading the counter over the bus with a value equal to a compare register, or with any value, sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flag clearing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| cnt_en | input | 1 | Count enable, one step per clock |
| tmr_out | output | 1 | Timer output pin |
| conv_req | output | 1 | Single-cycle conversion-start request |

## Verification
The bench tests the clearing exchange from several sides:
- A bare write of zero must leave a flag set. A design that cleared on any zero write would drop it.
- A read is consumed by one clearing write, so a later write without a fresh read must not clear. A design that kept the read armed would clear there.
- A hardware set in the same cycle as a valid clear must win. A design with clear priority would report 0.

It drives every pin action, including toggling twice in a row, and checks that the pin holds between matches. It checks that `conv_req` lasts exactly one cycle and is absent while the trigger is disabled. It also loads the counter with a compare value to show that a bus load causes no match.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPA  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPB  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd3;

  // flag vector index i maps to control/status bit FLAG_LSB+i
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_LSB  = 5;
  localparam int FIDX_OVF  = 0;
  localparam int FIDX_A    = 1;
  localparam int FIDX_B    = 2;
  localparam int TRIG_BIT  = 4;
  localparam int ACT_LSB   = 2;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'b00,
    PIN_LOW    = 2'b01,
    PIN_HIGH   = 2'b10,
    PIN_TOGGLE = 2'b11
  } pin_act_e;
endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_wr,
  input  logic             cmpa_wr,
  input  logic             cmpb_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmpa_q,
  output logic [CNT_W-1:0] cmpb_q,
  output logic             hit_a,
  output logic             hit_b,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             step;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    step    = cnt_en & ~cnt_wr;
    cnt_inc = cnt_q + 1'b1;
    hit_a   = step & (cnt_inc == cmpa_q);
    hit_b   = step & (cnt_inc == cmpb_q);
    wrap    = step & (cnt_q == CNT_TOP);
    if (cnt_wr)      cnt_d = wdata;
    else if (cnt_en) cnt_d = cnt_inc;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmpa_q <= CMP_RST;
      cmpb_q <= CMP_RST;
    end else begin
      cnt_q <= cnt_d;
      if (cmpa_wr) cmpa_q <= wdata;
      if (cmpb_wr) cmpb_q <= wdata;
    end
  end
endmodule

// File: rtl/mtmr_flag.sv
module mtmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_q
);
  logic arm_q, arm_d, flag_d, zero_wr, clr;

  always_comb begin
    zero_wr = wr_stb & ~wr_bit;
    clr     = zero_wr & arm_q & flag_q;
    flag_d  = set_evt | (flag_q & ~clr);
    if (zero_wr)               arm_d = 1'b0;
    else if (rd_stb && flag_q) arm_d = 1'b1;
    else                       arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/mtmr_pin.sv
module mtmr_pin
  import mtmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_b,
  input  pin_act_e act,
  output logic     pin_q
);
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    if (hit_b) begin
      case (act)
        PIN_LOW:    pin_d = 1'b0;
        PIN_HIGH:   pin_d = 1'b1;
        PIN_TOGGLE: pin_d = ~pin_q;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cnt_en,
  output logic              tmr_out,
  output logic              conv_req
);
  logic [DATA_W-1:0]    cnt_q, cmpa_q, cmpb_q;
  logic                 hit_a, hit_b, wrap;
  logic                 ctrl_wr, ctrl_rd;
  logic [NUM_FLAGS-1:0] set_vec, flag_vec;
  logic                 trig_en_q, trig_en_d;
  logic [1:0]           act_q, act_d;
  logic                 req_d;

  always_comb begin
    ctrl_wr   = reg_wr & (reg_addr == ADR_CTRL);
    ctrl_rd   = reg_rd & (reg_addr == ADR_CTRL);
    trig_en_d = ctrl_wr ? reg_wdata[TRIG_BIT] : trig_en_q;
    act_d     = ctrl_wr ? reg_wdata[ACT_LSB+1:ACT_LSB] : act_q;
    req_d     = hit_a & trig_en_q;
    set_vec[FIDX_OVF] = wrap;
    set_vec[FIDX_A]   = hit_a;
    set_vec[FIDX_B]   = hit_b;
  end

  mtmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_wr  (reg_wr & (reg_addr == ADR_COUNT)),
    .cmpa_wr (reg_wr & (reg_addr == ADR_CMPA)),
    .cmpb_wr (reg_wr & (reg_addr == ADR_CMPB)),
    .wdata   (reg_wdata),
    .cnt_q   (cnt_q),
    .cmpa_q  (cmpa_q),
    .cmpb_q  (cmpb_q),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .wrap    (wrap)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    mtmr_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec[i]),
      .rd_stb  (ctrl_rd),
      .wr_stb  (ctrl_wr),
      .wr_bit  (reg_wdata[FLAG_LSB+i]),
      .flag_q  (flag_vec[i])
    );
  end

  mtmr_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_b (hit_b),
    .act   (pin_act_e'(act_q)),
    .pin_q (tmr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_en_q <= 1'b0;
      act_q     <= 2'b00;
      conv_req  <= 1'b0;
    end else begin
      trig_en_q <= trig_en_d;
      act_q     <= act_d;
      conv_req  <= req_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_COUNT: reg_rdata = cnt_q;
      ADR_CMPA:  reg_rdata = cmpa_q;
      ADR_CMPB:  reg_rdata = cmpb_q;
      default:   reg_rdata = {flag_vec, trig_en_q, act_q, 2'b00};
    endcase
  end
endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       cnt_en,
  input logic       tmr_out,
  input logic       conv_req,
  input logic [2:0] flag_vec,
  input logic       trig_en_q
);
  for (genvar i = 0; i < 3; i++) begin : g_fl
    AST_FLAG_FALL_NEEDS_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_vec[i]) |-> $past(reg_wr && reg_addr == 2'd3 && !reg_wdata[5+i])); // R6
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R8

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(trig_en_q)); // R8

  AST_REQ_WITH_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> flag_vec[1]); // R4

  AST_PIN_MOVES_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmr_out) |-> $past(cnt_en)); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata[1:0] == 2'b00)); // R2
endmodule

bind mtmr_top mtmr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cnt_en    (cnt_en),
  .tmr_out   (tmr_out),
  .conv_req  (conv_req),
  .flag_vec  (flag_vec),
  .trig_en_q (trig_en_q)
);

// File: tb/mtmr_top_test.sv
module mtmr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_en = 1'b0;
  logic       tmr_out;
  logic       conv_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mtmr_top uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_en(cnt_en), .tmr_out(tmr_out), .conv_req(conv_req)
  );

  // vector: [23:20] requirement, [19:18] kind, [17:16] addr, [15:8] data/count, [7:0] expected
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_RUN = 2'd2;
  localparam int NV = 41;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  K_RD,  2'd3, 8'h00, 8'h00},  // R1 ctrl reset
    {4'd1,  K_RD,  2'd0, 8'h00, 8'h00},  // R1 counter reset
    {4'd1,  K_RD,  2'd1, 8'h00, 8'hFF},  // R1 compare A reset
    {4'd1,  K_RD,  2'd2, 8'h00, 8'hFF},  // R1 compare B reset
    {4'd2,  K_WR,  2'd1, 8'h10, 8'h00},
    {4'd2,  K_WR,  2'd2, 8'h20, 8'h00},
    {4'd2,  K_RD,  2'd1, 8'h00, 8'h10},  // R2 readback
    {4'd2,  K_RD,  2'd2, 8'h00, 8'h20},
    {4'd2,  K_WR,  2'd3, 8'hFF, 8'h00},
    {4'd2,  K_RD,  2'd3, 8'h00, 8'h1C},  // R2 reserved bits, R6 write 1 sets nothing
    {4'd2,  K_WR,  2'd3, 8'h00, 8'h00},
    {4'd2,  K_RD,  2'd3, 8'h00, 8'h00},
    {4'd3,  K_WR,  2'd0, 8'h0E, 8'h00},
    {4'd3,  K_RUN, 2'd0, 8'd2,  8'h00},
    {4'd3,  K_RD,  2'd0, 8'h00, 8'h10},  // R3 increment
    {4'd4,  K_RD,  2'd3, 8'h00, 8'h40},  // R4 flag A (read arms)
    {4'd6,  K_WR,  2'd3, 8'h00, 8'h00},
    {4'd6,  K_RD,  2'd3, 8'h00, 8'h00},  // R6 armed clear
    {4'd4,  K_RUN, 2'd0, 8'd16, 8'h00},
    {4'd6,  K_WR,  2'd3, 8'h00, 8'h00},  // zero write with no prior read
    {4'd6,  K_RD,  2'd3, 8'h00, 8'h80},  // R4 flag B, R6 survives bare write
    {4'd6,  K_WR,  2'd3, 8'h80, 8'h00},  // write 1 to armed flag
    {4'd6,  K_RD,  2'd3, 8'h00, 8'h80},  // R6 write 1 no effect
    {4'd6,  K_WR,  2'd3, 8'h00, 8'h00},
    {4'd6,  K_RD,  2'd3, 8'h00, 8'h00},  // R6 cleared
    {4'd5,  K_WR,  2'd0, 8'hFE, 8'h00},
    {4'd5,  K_RUN, 2'd0, 8'd2,  8'h00},
    {4'd5,  K_RD,  2'd0, 8'h00, 8'h00},  // R5 wrapped
    {4'd5,  K_RD,  2'd3, 8'h00, 8'h20},  // R5 overflow flag
    {4'd6,  K_WR,  2'd3, 8'h00, 8'h00},  // clears, cancels arm
    {4'd6,  K_WR,  2'd0, 8'hFF, 8'h00},
    {4'd6,  K_RUN, 2'd0, 8'd1,  8'h00},
    {4'd6,  K_WR,  2'd3, 8'h00, 8'h00},  // arm was consumed
    {4'd6,  K_RD,  2'd3, 8'h00, 8'h20},  // R6 arm cancelled
    {4'd10, K_WR,  2'd0, 8'h10, 8'h00},  // load equal to compare A
    {4'd10, K_WR,  2'd0, 8'h20, 8'h00},  // load equal to compare B
    {4'd10, K_RD,  2'd3, 8'h00, 8'h20},  // R10 no flag from load
    {4'd3,  K_WR,  2'd3, 8'h00, 8'h00},
    {4'd3,  K_RD,  2'd3, 8'h00, 8'h00},
    {4'd3,  K_RUN, 2'd0, 8'd3,  8'h00},
    {4'd3,  K_RD,  2'd0, 8'h00, 8'h23}   // R3 counts from loaded value
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input int req, input logic [1:0] a, input logic [7:0] exp, input logic [7:0] mask);
    reg_addr = a; reg_rd = 1'b1;
    #1 check(req, reg_rdata & mask, exp & mask);
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, {6'd0, tmr_out, conv_req}, 8'h00);  // R1 outputs during reset
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][19:18])
        K_WR:    bus_wr(VEC[v][17:16], VEC[v][15:8]);
        K_RD:    bus_rd(int'(VEC[v][23:20]), VEC[v][17:16], VEC[v][7:0], 8'hFF);
        default: run(int'(VEC[v][15:8]));
      endcase
    end

    // R8: request disabled, then enabled
    bus_wr(2'd1, 8'h30);
    bus_wr(2'd0, 8'h2F);
    run(1);
    check(8, {7'd0, conv_req}, 8'h00);  // R8 no request when disabled
    bus_wr(2'd3, 8'h10);
    bus_wr(2'd0, 8'h2F);
    cnt_en = 1'b1;
    @(posedge clk); @(negedge clk);
    cnt_en = 1'b0;
    check(8, {7'd0, conv_req}, 8'h01);  // R8 pulse present
    @(negedge clk);
    check(8, {7'd0, conv_req}, 8'h00);  // R8 pulse one cycle

    // R9: pin actions on compare B = 0x40
    bus_wr(2'd2, 8'h40);
    bus_wr(2'd3, 8'h08);  // drive 1
    check(9, {7'd0, tmr_out}, 8'h00);   // R9 unchanged before match
    bus_wr(2'd0, 8'h3F); run(1);
    check(9, {7'd0, tmr_out}, 8'h01);   // R9 drive high
    bus_wr(2'd3, 8'h0C);  // toggle
    bus_wr(2'd0, 8'h3F); run(1);
    check(9, {7'd0, tmr_out}, 8'h00);   // R9 toggle
    bus_wr(2'd0, 8'h3F); run(1);
    check(9, {7'd0, tmr_out}, 8'h01);   // R9 toggle again
    bus_wr(2'd3, 8'h00);  // hold
    bus_wr(2'd0, 8'h3F); run(1);
    check(9, {7'd0, tmr_out}, 8'h01);   // R9 hold
    bus_wr(2'd3, 8'h04);  // drive 0
    run(4);
    check(9, {7'd0, tmr_out}, 8'h01);   // R9 no change without match
    bus_wr(2'd0, 8'h3F); run(1);
    check(9, {7'd0, tmr_out}, 8'h00);   // R9 drive low

    // R7: set event coincides with valid clearing write of flag A
    bus_wr(2'd1, 8'h50);
    bus_wr(2'd0, 8'h4F); run(1);
    bus_rd(4, 2'd3, 8'h40, 8'h40);      // R4 flag A set, read arms
    bus_wr(2'd0, 8'h4F);
    reg_addr = 2'd3; reg_wdata = 8'h00; reg_wr = 1'b1; cnt_en = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; cnt_en = 1'b0;
    bus_rd(7, 2'd3, 8'h40, 8'h40);      // R7 set wins
    bus_wr(2'd3, 8'h00);
    bus_rd(7, 2'd3, 8'h00, 8'h40);      // R7 then clears on armed write

    finish_run();
  end
endmodule